// File: doc/BRIEF.md
# Radix-4 256-point FFT engine

This block computes the forward discrete Fourier transform of a 256-sample complex frame. Samples arrive one per clock on a valid/ready port. A start-of-frame flag marks sample zero. Each accepted sample is stored at its base-4 digit-reversed position in one half of a two-bank memory. The engine then makes four radix-4 decimation-in-time passes. Each pass reads one bank and writes the other, and the two banks swap roles after every pass. Twiddle factors come from an internal read-only table.

The butterfly takes four complex operands in each cycle and works through three register levels: operand and twiddle fetch, complex multiply, then the four-point combine with a divide-by-four. A single state machine drives the loading, the 64 butterflies of each pass, a three-cycle drain between passes and the readout. The transform leaves in natural bin order as a burst of 256 valid cycles. The last of these cycles is flagged, and a one-cycle done pulse comes just before the burst. The port accepts no input from the final sample of a frame until the final output sample is presented.

Top module: `fft4_top`

## Requirements
- R1: After reset, inReady is 1 and outValid, outLast and done are all 0.
- R2: An accepted sample with inSof=1 becomes sample index 0 of a new frame, even if a frame is partly loaded. Accepted samples are discarded until the first sample with inSof=1 arrives after reset or after a completed frame.
- R3: A sample is accepted when inValid and inReady are both 1 on a rising edge. After 256 samples of a frame have been accepted, inReady falls on the next cycle. Sample n is stored at the index whose four base-4 digits (2-bit fields) are those of n in reverse order.
- R4: Output bin k (re and im, signed 16-bit two's complement) equals (1/256)·Σn x[n]·exp(-j2πkn/256), to within ±4 LSB. The factor comes from scaling every butterfly result by 1/4 (arithmetic shift right by 2). Twiddles are Q1.15 values of exp(-j2πk/256) for k=0..191. A twiddle with exponent 0 bypasses the multiplier.
- R5: Each pass issues one butterfly per cycle for 64 cycles. Each butterfly result is written three cycles after its operands are read. The engine waits three idle cycles after each pass before the next pass or the readout, and done is high after the 268th rising edge that follows the edge accepting the final sample.
- R6: Starting the cycle after done, outValid is high for exactly 256 consecutive cycles, carrying bins 0..255 in natural order. outLast is high only with bin 255.
- R7: inReady is 0 from the cycle after the final sample is accepted up to the cycle in which outLast is presented, when it returns to 1. Inputs offered while inReady is 0 do not change any result.
- R8: done is a single-cycle pulse, given once per frame.
- R9: A new frame may begin as soon as inReady returns. Its results do not depend on any earlier frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Input sample offered |
| inSof | input | 1 | Offered sample is index 0 of a frame |
| inRe | input | 16 | Input sample real part, signed |
| inIm | input | 16 | Input sample imaginary part, signed |
| inReady | output | 1 | Engine can accept a sample |
| outValid | output | 1 | Output bin present |
| outLast | output | 1 | Output bin is bin 255 |
| outRe | output | 16 | Output bin real part, signed |
| outIm | output | 16 | Output bin imaginary part, signed |
| done | output | 1 | Transform complete, one-cycle pulse |

## Verification
On every cycle, the assertions watch the pipeline discipline. Writes in flight never target the bank being read. Loads never overlap butterfly traffic. Each pass starts only with an empty pipeline, and results land exactly three cycles after issue. They also check that done is one cycle wide, that it leads the output burst, and that inReady only returns together with outLast. The numeric result can only be shown by the bench scenarios, which compare each bin against a bench-computed DFT: the digit-reversed storage, the twiddle values, the -j handling and the accumulated truncation error. The same holds for discarding samples before the start flag, restarting on a second start flag, ignoring inputs during computation and running frames back to back.

// File: rtl/fft4_pkg.sv
package fft4_pkg;
  localparam int LOG4N = 4;               // radix-4 passes
  localparam int NPTS = 1 << (2 * LOG4N); // transform length
  localparam int AW = 2 * LOG4N;          // sample index width
  localparam int BW = AW - 2;             // butterfly index width
  localparam int SW = $clog2(LOG4N);      // pass counter width
  localparam int DW = 16;                 // sample component width
  localparam int TW = 16;                 // twiddle component width
  localparam int PIPE_DEPTH = 3;          // butterfly register levels

  typedef enum logic [1:0] {ST_LOAD, ST_RUN, ST_DRAIN, ST_OUT} fsmState_t;

  typedef struct packed {
    logic          load;
    logic [AW-1:0] loadIdx;
    logic          bfly;
    logic [SW-1:0] pass;
    logic [BW-1:0] bIdx;
    logic          outRd;
    logic [AW-1:0] outIdx;
  } strobe_t;
endpackage

// File: rtl/fft4_ctrl.sv
module fft4_ctrl
  import fft4_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    inValid,
  input  logic    inSof,
  output logic    inReady,
  output logic    done,
  output strobe_t strb
);
  localparam int DCW = $clog2(PIPE_DEPTH);

  fsmState_t      state;
  logic [AW-1:0]  cnt;
  logic           started;
  logic [SW-1:0]  pass;
  logic [BW-1:0]  bIdx;
  logic [DCW-1:0] drainCnt;
  logic [AW-1:0]  outIdx;
  logic           keep;

  assign inReady = (state == ST_LOAD);
  assign keep    = inValid && inReady && (inSof || started);

  always_comb begin
    strb.load    = keep;
    strb.loadIdx = inSof ? '0 : cnt;
    strb.bfly    = (state == ST_RUN);
    strb.pass    = pass;
    strb.bIdx    = bIdx;
    strb.outRd   = (state == ST_OUT);
    strb.outIdx  = outIdx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_LOAD;
      cnt      <= '0;
      started  <= 1'b0;
      pass     <= '0;
      bIdx     <= '0;
      drainCnt <= '0;
      outIdx   <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_LOAD: if (keep) begin
          if (strb.loadIdx == AW'(NPTS - 1)) begin
            state   <= ST_RUN;
            cnt     <= '0;
            started <= 1'b0;
            pass    <= '0;
            bIdx    <= '0;
          end else begin
            started <= 1'b1;
            cnt     <= strb.loadIdx + AW'(1);
          end
        end
        ST_RUN: begin
          bIdx <= bIdx + BW'(1);
          if (bIdx == '1) begin
            state    <= ST_DRAIN;
            drainCnt <= '0;
          end
        end
        ST_DRAIN: begin
          drainCnt <= drainCnt + DCW'(1);
          if (drainCnt == DCW'(PIPE_DEPTH - 1)) begin
            if (pass == SW'(LOG4N - 1)) begin
              state  <= ST_OUT;
              outIdx <= '0;
              done   <= 1'b1;
            end else begin
              pass  <= pass + SW'(1);
              state <= ST_RUN;
            end
          end
        end
        default: begin
          outIdx <= outIdx + AW'(1);
          if (outIdx == AW'(NPTS - 1)) state <= ST_LOAD;
        end
      endcase
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8
endmodule

// File: rtl/fft4_dp.sv
module fft4_dp
  import fft4_pkg::*;
#(
  parameter int DATW = DW,
  parameter int TWW  = TW
) (
  input  logic                   clk,
  input  logic                   rst,
  input  strobe_t                strb,
  input  logic signed [DATW-1:0] inRe,
  input  logic signed [DATW-1:0] inIm,
  output logic                   outValid,
  output logic                   outLast,
  output logic signed [DATW-1:0] outRe,
  output logic signed [DATW-1:0] outIm
);
  localparam int PW   = DATW + 2;
  localparam int SUMW = PW + 2;
  localparam int MULW = DATW + TWW + 1;
  localparam int TWN  = 3 * NPTS / 4;

  logic signed [DATW-1:0] memRe [2][NPTS];
  logic signed [DATW-1:0] memIm [2][NPTS];
  logic signed [TWW-1:0]  twRe [TWN];
  logic signed [TWW-1:0]  twIm [TWN];

  // twiddle table: exp(-j*2*pi*k/NPTS) in Q1.(TWW-1)
  initial begin
    for (int k = 0; k < TWN; k++) begin
      real ang, scl;
      scl = real'((1 << (TWW - 1)) - 1);
      ang = 2.0 * 3.14159265358979 * real'(k) / real'(NPTS);
      twRe[k] = TWW'(int'(scl * $cos(ang)));
      twIm[k] = TWW'(int'(-scl * $sin(ang)));
    end
  end

  function automatic logic [AW-1:0] digRev(input logic [AW-1:0] a);
    logic [AW-1:0] r;
    for (int d = 0; d < LOG4N; d++) r[2*d +: 2] = a[2*(LOG4N-1-d) +: 2];
    return r;
  endfunction

  function automatic logic signed [DATW-1:0] sat(input logic signed [SUMW-1:0] v);
    if (v > $signed(SUMW'(2 ** (DATW - 1) - 1))) return {1'b0, {(DATW-1){1'b1}}};
    if (v < -$signed(SUMW'(2 ** (DATW - 1))))    return {1'b1, {(DATW-1){1'b0}}};
    return DATW'(v);
  endfunction

  // operand addresses and twiddle exponents for the issued butterfly
  logic [AW-1:0] rdAddr [4];
  logic [AW-1:0] twIdx  [4];
  always_comb begin
    int sh;
    logic [AW-1:0] mask, jj, base;
    sh   = 2 * int'(strb.pass);
    mask = AW'((1 << sh) - 1);
    jj   = AW'(strb.bIdx) & mask;
    base = ((AW'(strb.bIdx) >> sh) << (sh + 2)) | jj;
    for (int m = 0; m < 4; m++) begin
      rdAddr[m] = base + (AW'(m) << sh);
      twIdx[m]  = (jj * AW'(m)) << (2 * (LOG4N - 1) - sh);
    end
  end

  logic                   p1v, p2v, p3v, p1Bank, p2Bank, p3Bank;
  logic [AW-1:0]          p1Addr [4], p2Addr [4], p3Addr [4];
  logic signed [DATW-1:0] p1Re [4], p1Im [4];
  logic signed [TWW-1:0]  p1Wr [4], p1Wi [4];
  logic                   p1Byp [4];
  logic signed [PW-1:0]   p2Re [4], p2Im [4];
  logic signed [DATW-1:0] p3Re [4], p3Im [4];

  logic signed [MULW-1:0] mulRe [4], mulIm [4];
  always_comb begin
    for (int m = 0; m < 4; m++) begin
      mulRe[m] = MULW'(p1Re[m]) * MULW'(p1Wr[m]) - MULW'(p1Im[m]) * MULW'(p1Wi[m]);
      mulIm[m] = MULW'(p1Re[m]) * MULW'(p1Wi[m]) + MULW'(p1Im[m]) * MULW'(p1Wr[m]);
    end
  end

  // four-point combine; -j*(x+jy) = y - jx
  logic signed [SUMW-1:0] eRe [4], eIm [4], bRe [4], bIm [4];
  always_comb begin
    for (int m = 0; m < 4; m++) begin
      eRe[m] = SUMW'(p2Re[m]);
      eIm[m] = SUMW'(p2Im[m]);
    end
    bRe[0] = eRe[0] + eRe[1] + eRe[2] + eRe[3];
    bIm[0] = eIm[0] + eIm[1] + eIm[2] + eIm[3];
    bRe[1] = eRe[0] + eIm[1] - eRe[2] - eIm[3];
    bIm[1] = eIm[0] - eRe[1] - eIm[2] + eRe[3];
    bRe[2] = eRe[0] - eRe[1] + eRe[2] - eRe[3];
    bIm[2] = eIm[0] - eIm[1] + eIm[2] - eIm[3];
    bRe[3] = eRe[0] - eIm[1] - eRe[2] + eIm[3];
    bIm[3] = eIm[0] + eRe[1] - eIm[2] - eRe[3];
  end

  always_ff @(posedge clk) begin
    if (strb.load) begin
      memRe[0][digRev(strb.loadIdx)] <= inRe;
      memIm[0][digRev(strb.loadIdx)] <= inIm;
    end
    if (p3v) begin
      for (int m = 0; m < 4; m++) begin
        memRe[p3Bank][p3Addr[m]] <= p3Re[m];
        memIm[p3Bank][p3Addr[m]] <= p3Im[m];
      end
    end
    p1Bank <= ~strb.pass[0];
    p2Bank <= p1Bank;
    p3Bank <= p2Bank;
    for (int m = 0; m < 4; m++) begin
      p1Addr[m] <= rdAddr[m];
      p1Re[m]   <= memRe[strb.pass[0]][rdAddr[m]];
      p1Im[m]   <= memIm[strb.pass[0]][rdAddr[m]];
      p1Wr[m]   <= twRe[twIdx[m]];
      p1Wi[m]   <= twIm[twIdx[m]];
      p1Byp[m]  <= (twIdx[m] == '0);
      p2Addr[m] <= p1Addr[m];
      p2Re[m]   <= p1Byp[m] ? PW'(p1Re[m]) : PW'(mulRe[m] >>> (TWW - 1));
      p2Im[m]   <= p1Byp[m] ? PW'(p1Im[m]) : PW'(mulIm[m] >>> (TWW - 1));
      p3Addr[m] <= p2Addr[m];
      p3Re[m]   <= sat(bRe[m] >>> 2);
      p3Im[m]   <= sat(bIm[m] >>> 2);
    end
    if (strb.outRd) begin
      outRe <= memRe[0][strb.outIdx];
      outIm <= memIm[0][strb.outIdx];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      p1v      <= 1'b0;
      p2v      <= 1'b0;
      p3v      <= 1'b0;
      outValid <= 1'b0;
      outLast  <= 1'b0;
    end else begin
      p1v      <= strb.bfly;
      p2v      <= p1v;
      p3v      <= p2v;
      outValid <= strb.outRd;
      outLast  <= strb.outRd && (strb.outIdx == AW'(NPTS - 1));
    end
  end

  AST_PINGPONG_SEP: assert property (@(posedge clk) disable iff (rst)
    (p3v && strb.bfly) |-> (p3Bank != strb.pass[0])); // R5
  AST_PIPE_THREE: assert property (@(posedge clk) disable iff (rst)
    p3v |-> $past(strb.bfly, 3)); // R5
  AST_PASS_DRAINED: assert property (@(posedge clk) disable iff (rst)
    (strb.bfly && !$past(strb.bfly)) |-> !(p1v || p2v || p3v)); // R5
  AST_LOAD_QUIET: assert property (@(posedge clk) disable iff (rst)
    strb.load |-> !(p1v || p2v || p3v)); // R7
  AST_READ_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
    strb.outRd |-> !p3v); // R6
endmodule

// File: rtl/fft4_top.sv
module fft4_top
  import fft4_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 inValid,
  input  logic                 inSof,
  input  logic signed [DW-1:0] inRe,
  input  logic signed [DW-1:0] inIm,
  output logic                 inReady,
  output logic                 outValid,
  output logic                 outLast,
  output logic signed [DW-1:0] outRe,
  output logic signed [DW-1:0] outIm,
  output logic                 done
);
  strobe_t strb;

  fft4_ctrl u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .inSof(inSof),
    .inReady(inReady), .done(done), .strb(strb)
  );

  fft4_dp #(.DATW(DW), .TWW(TW)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .inRe(inRe), .inIm(inIm),
    .outValid(outValid), .outLast(outLast), .outRe(outRe), .outIm(outIm)
  );

  AST_OUT_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    $rose(outValid) |-> $past(done)); // R6
  AST_READY_ON_LAST: assert property (@(posedge clk) disable iff (rst)
    $rose(inReady) |-> outLast); // R7
endmodule

// File: tb/tb_fft4_top.sv
`timescale 1ns/1ps
module tb_fft4_top;
  logic clk = 1'b0;
  logic rst;
  logic inValid, inSof, inReady, outValid, outLast, done;
  logic signed [15:0] inRe, inIm, outRe, outIm;

  always #10 clk = ~clk;

  fft4_top dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inSof(inSof),
    .inRe(inRe), .inIm(inIm), .inReady(inReady), .outValid(outValid),
    .outLast(outLast), .outRe(outRe), .outIm(outIm), .done(done)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int outFrames = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int  mPhase, mCnt, mC;
  bit  mStarted, mTail;
  int  mXr [256], mXi [256];
  real eRe [$], eIm [$];
  real cosT [256], sinT [256];

  initial begin
    for (int i = 0; i < 256; i++) begin
      cosT[i] = $cos(2.0 * 3.14159265358979 * i / 256.0);
      sinT[i] = $sin(2.0 * 3.14159265358979 * i / 256.0);
    end
  end

  task automatic pushDft();
    for (int k = 0; k < 256; k++) begin
      real sr, si;
      sr = 0.0; si = 0.0;
      for (int n = 0; n < 256; n++) begin
        int p;
        p = (k * n) % 256;
        sr += mXr[n] * cosT[p] + mXi[n] * sinT[p];
        si += mXi[n] * cosT[p] - mXr[n] * sinT[p];
      end
      eRe.push_back(sr / 256.0);
      eIm.push_back(si / 256.0);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      mPhase = 0; mCnt = 0; mC = 0; mStarted = 0; mTail = 0;
      eRe.delete(); eIm.delete();
    end else begin
      mTail = 0;
      if (mPhase == 0) begin
        if (inValid) begin
          int idx;
          idx = inSof ? 0 : (mStarted ? mCnt : -1);
          if (idx >= 0) begin
            mStarted = 1;
            mXr[idx] = int'(inRe);
            mXi[idx] = int'(inIm);
            mCnt = idx + 1;
            if (mCnt == 256) begin
              pushDft();
              mPhase = 1; mC = 1; mCnt = 0; mStarted = 0;
            end
          end
        end
      end else if (mC == 524) begin
        mPhase = 0; mTail = 1;
      end else begin
        mC++;
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      bit xReady, xDone, xOv, xOl;
      xReady = (mPhase == 0);
      xDone  = (mPhase == 1) && (mC == 269);
      xOv    = ((mPhase == 1) && (mC >= 270)) || mTail;
      xOl    = mTail;
      chk(inReady == xReady, "R3 R7 inReady", int'(inReady), int'(xReady));
      chk(done == xDone, "R5 R8 done", int'(done), int'(xDone));
      chk(outValid == xOv, "R6 outValid", int'(outValid), int'(xOv));
      chk(outLast == xOl, "R6 outLast", int'(outLast), int'(xOl));
      if (outValid && outLast) outFrames++;
      if (outValid && xOv) begin
        if (eRe.size() == 0) begin
          chk(1'b0, "R4 unexpected bin", 1, 0);
        end else begin
          real er, ei, dr, di;
          er = eRe.pop_front();
          ei = eIm.pop_front();
          dr = real'(int'(outRe)) - er; if (dr < 0.0) dr = -dr;
          di = real'(int'(outIm)) - ei; if (di < 0.0) di = -di;
          chk(dr <= 4.0, "R4 bin re", int'(outRe), int'(er));
          chk(di <= 4.0, "R4 bin im", int'(outIm), int'(ei));
        end
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic push(input int re, input int im, input bit sof);
    @(negedge clk);
    inValid = 1'b1; inSof = sof; inRe = 16'(re); inIm = 16'(im);
    while (!inReady) @(negedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    inValid = 1'b0; inSof = 1'b0;
  endtask

  // R7: offer junk while the engine is busy
  task automatic junk(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (inReady) begin
        inValid = 1'b0; inSof = 1'b0;
        return;
      end
      inValid = 1'b1; inSof = 1'b1; inRe = 16'(777 + i); inIm = -16'(i);
    end
    inValid = 1'b0; inSof = 1'b0;
  endtask

  task automatic sendFrame(input int kind);
    for (int n = 0; n < 256; n++) begin
      int re, im;
      real a;
      re = 0; im = 0;
      case (kind)
        0: re = (n == 0) ? 16000 : 0;
        1: re = 8000;
        2: begin
          a  = 2.0 * 3.14159265358979 * 5.0 * n / 256.0;
          re = int'(12000.0 * $cos(a));
          im = int'(12000.0 * $sin(a));
        end
        default: begin
          a  = 2.0 * 3.14159265358979 * 17.0 * n / 256.0;
          re = int'(10000.0 * $cos(a)) + ((n == 3) ? 4000 : 0);
        end
      endcase
      push(re, im, n == 0);
    end
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      fails++;
      $display("FAIL R5 watchdog actual=%0d expected=%0d", cyc, 20000);
      finishRun();
    end
  end

  initial begin
    rst = 1'b1; inValid = 1'b0; inSof = 1'b0; inRe = '0; inIm = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(inReady == 1'b1, "R1 reset inReady", int'(inReady), 1);
    chk(outValid == 1'b0, "R1 reset outValid", int'(outValid), 0);
    chk(outLast == 1'b0, "R1 reset outLast", int'(outLast), 0);
    chk(done == 1'b0, "R1 reset done", int'(done), 0);

    // R2: samples before the first start flag are dropped
    for (int i = 0; i < 5; i++) push(3000 + i, -1000, 1'b0);
    sendFrame(0);                    // impulse
    idle();
    junk(600);                       // R7: ignored while busy

    // R2: a second start flag restarts a partial frame
    for (int i = 0; i < 7; i++) push(-5000, 2500, i == 0);
    sendFrame(1);                    // DC
    sendFrame(2);                    // R9: complex tone, back to back
    sendFrame(3);                    // R9: real tone plus shifted impulse
    idle();

    @(negedge clk);
    while (mPhase != 0 || eRe.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(outFrames == 4, "R2 R9 frames out", outFrames, 4);
    finishRun();
  end
endmodule